// File: doc/BRIEF.md
# Branch Outcome History Table

This block predicts whether a conditional branch will be taken. It keeps a small table of per-entry history, with no tags. The table is addressed by a slice of the branch's word address. A fetch-side lookup port gives a taken or not-taken guess in the same cycle, with no register between the address and the guess. A resolve-side update port writes the real outcome of a finished branch into the entry its address selects.

A parameter sets how much history each entry holds. With one bit, the entry remembers the last outcome and predicts that outcome again. With two bits, the entry is a saturating up/down counter, and its guess flips only after two wrong guesses in a row. Two free-running counters report how many lookups were made and how many resolved branches disagreed with the table. A bench can use them to measure accuracy.

Top module: `bht_predictor`

## Requirements
- R1: After a synchronous active-low reset, every entry predicts not-taken and both statistics counters read zero. In two-bit mode every entry starts at the weakly-not-taken value 2'b01.
- R2: The entry index is `pc[IDX_W+1:2]`, which is `pc[7:2]` for the default 64 entries. Address bits [1:0] and all bits above IDX_W+1 have no effect, so two addresses 256 bytes apart share one entry.
- R3: In one-bit mode (HIST_BITS=1), the prediction after an update equals the outcome written by the most recent update to that entry.
- R4: In two-bit mode (HIST_BITS=2), an entry counts up on taken and saturates at 2'b11. It counts down on not-taken and saturates at 2'b00. It predicts taken when its MSB is 1.
- R5: In two-bit mode, an entry at reset flips to predicting taken after one taken update. An entry at 2'b11 needs two not-taken updates before it predicts not-taken.
- R6: A saturated entry stays at its limit. After any number of taken updates, a single not-taken update still leaves the prediction taken.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from before the update. The new value is visible from the next cycle.
- R8: `stat_lookups` rises by exactly one in each cycle with `lk_valid` high and otherwise holds. It wraps at 2^CNT_W.
- R9: `stat_mispred` rises by one in each cycle where `upd_valid` is high and the entry's prediction before the update differs from `upd_taken`. Otherwise it holds.
- R10: An update changes only the entry its address selects. Other entries keep their predictions.
- R11: For a loop branch taken 9 times and then not taken, repeated, a warmed-up one-bit table mispredicts twice per loop: at the exit and at the next entry. A two-bit table mispredicts once per loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup is made this cycle (counted) |
| lk_pc | input | ADDR_W | Byte address of the branch being fetched |
| lk_pred | output | 1 | Combinational guess for `lk_pc`: 1 means taken |
| upd_valid | input | 1 | A resolved branch is written this cycle |
| upd_pc | input | ADDR_W | Byte address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| stat_lookups | output | CNT_W | Number of lookups since reset |
| stat_mispred | output | CNT_W | Number of resolved branches the table got wrong |

## Verification
A lookup and an update can land on the same entry in one clock cycle. The bench provokes this by driving both ports with the same address, or with aliased addresses, in a single cycle while the written outcome disagrees with the stored state. The bench judges the case by requiring the lookup to show the pre-update guess in that cycle and the updated guess in the next one. Two DUT copies, one per history width, receive identical stimulus. Their mismatch counts over a warmed-up loop separate the two modes.

// File: rtl/bht_pkg.sv
// Package: shared constants and helpers for the branch history table.
// Assumes the history width is 1 or 2 bits.
package bht_pkg;
    localparam logic [1:0] CNT_STRONG_NT = 2'b00;
    localparam logic [1:0] CNT_WEAK_NT   = 2'b01;
    localparam logic [1:0] CNT_WEAK_T    = 2'b10;
    localparam logic [1:0] CNT_STRONG_T  = 2'b11;

    // Reset value of one entry, given its width.
    function automatic logic [1:0] entry_reset(input int hist_bits);
        return (hist_bits == 2) ? CNT_WEAK_NT : 2'b00;
    endfunction
endpackage

// File: rtl/bht_index.sv
// Module: turns a byte address into a table index.
// Assumes instructions are word aligned: bits [1:0] are dropped,
// and bits above the index slice are dropped (no tag).
module bht_index #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    // Take the word-address slice used as the index.
    always_comb begin
        idx = pc[IDX_W+1:2];
    end
endmodule

// File: rtl/bht_state_next.sv
// Module: prediction and next state of one table entry.
// HIST_BITS selects a last-outcome bit (1) or a saturating counter (2).
module bht_state_next #(
    parameter int HIST_BITS = 2
) (
    input  logic [HIST_BITS-1:0] cur,
    input  logic                 taken,
    output logic [HIST_BITS-1:0] nxt,
    output logic                 pred
);
    import bht_pkg::*;

    generate
        if (HIST_BITS == 1) begin : g_last
            // The stored bit is both the guess and the history.
            always_comb begin
                pred = cur[0];
                nxt  = taken;
            end
        end else begin : g_sat
            // Saturating up/down counter; the MSB is the guess.
            always_comb begin
                pred = cur[HIST_BITS-1];
                nxt  = cur;
                if (taken && cur != CNT_STRONG_T)
                    nxt = cur + 2'd1;
                else if (!taken && cur != CNT_STRONG_NT)
                    nxt = cur - 2'd1;
            end
        end
    endgenerate
endmodule

// File: rtl/bht_stats.sv
// Module: lookup and misprediction counters.
// Assumes wrap-around at 2^CNT_W is acceptable.
module bht_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_event,
    input  logic             miss_event,
    output logic [CNT_W-1:0] n_lookups,
    output logic [CNT_W-1:0] n_miss
);
    // Count lookups and wrong guesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_lookups <= '0;
            n_miss    <= '0;
        end else begin
            if (lk_event)   n_lookups <= n_lookups + 1'b1;
            if (miss_event) n_miss    <= n_miss + 1'b1;
        end
    end

    p_lookup_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_event |=> n_lookups == $past(n_lookups) + 1'b1)
        else $error("R8 lookup count did not step");
    p_lookup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_event |=> $stable(n_lookups))
        else $error("R8 lookup count moved without lookup");
    p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_event |=> $stable(n_miss))
        else $error("R9 miss count moved without miss");
endmodule

// File: rtl/bht_predictor.sv
// Module: untagged branch history table with one lookup port and one
// update port. The lookup is combinational. Updates land on the clock
// edge, so a same-cycle lookup sees the old entry. Assumes word-aligned
// branch addresses and HIST_BITS of 1 or 2.
module bht_predictor #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int HIST_BITS = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_pred,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    output logic [CNT_W-1:0]  stat_lookups,
    output logic [CNT_W-1:0]  stat_mispred
);
    import bht_pkg::*;

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [HIST_BITS-1:0] RST_VAL = HIST_BITS'(entry_reset(HIST_BITS));

    logic [HIST_BITS-1:0] table_q [DEPTH];
    logic [IDX_W-1:0]     lk_idx, upd_idx;
    logic [HIST_BITS-1:0] lk_state, upd_state, upd_next, lk_unused_nxt;
    logic                 upd_pred;

    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_idx  (.pc(lk_pc),  .idx(lk_idx));
    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_idx (.pc(upd_pc), .idx(upd_idx));

    // Read both ports from the stored table.
    always_comb begin
        lk_state  = table_q[lk_idx];
        upd_state = table_q[upd_idx];
    end

    bht_state_next #(.HIST_BITS(HIST_BITS)) u_lk_state (
        .cur(lk_state), .taken(1'b0), .nxt(lk_unused_nxt), .pred(lk_pred));
    bht_state_next #(.HIST_BITS(HIST_BITS)) u_upd_state (
        .cur(upd_state), .taken(upd_taken), .nxt(upd_next), .pred(upd_pred));

    // Reset every entry, or write the resolved outcome into one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= RST_VAL;
        end else if (upd_valid) begin
            table_q[upd_idx] <= upd_next;
        end
    end

    bht_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n),
        .lk_event(lk_valid),
        .miss_event(upd_valid && (upd_pred != upd_taken)),
        .n_lookups(stat_lookups), .n_miss(stat_mispred));

    generate
        if (HIST_BITS == 1) begin : g_chk_last
            p_follow_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> table_q[$past(upd_idx)][0] == $past(upd_taken))
                else $error("R3 entry does not hold last outcome");
        end else begin : g_chk_sat
            p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_taken && upd_state == CNT_STRONG_T)
                |=> table_q[$past(upd_idx)] == CNT_STRONG_T)
                else $error("R4 counter left upper limit");
            p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && !upd_taken && upd_state == CNT_STRONG_NT)
                |=> table_q[$past(upd_idx)] == CNT_STRONG_NT)
                else $error("R4 counter left lower limit");
        end
    endgenerate
endmodule

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb;
    localparam int CW = 16;

    typedef struct {
        int    dut;   // 0: two-bit copy, 1: one-bit copy
        bit    exp;
        string tag;
    } item_t;

    logic clk = 0;
    logic rst_n = 0;
    logic lk_v = 0, up_v = 0, up_t = 0;
    logic [31:0] lk_pc = '0, up_pc = '0;
    logic pred2, pred1;
    logic [CW-1:0] lk2, mp2, lk1, mp1;

    int n_chk = 0, n_err = 0;
    item_t sb[$];
    int m2 [64];
    int m1 [64];
    int e_lk = 0, e_mp2 = 0, e_mp1 = 0;

    always #5 clk = ~clk;

    bht_predictor #(.HIST_BITS(2), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_pc(lk_pc), .lk_pred(pred2),
        .upd_valid(up_v), .upd_pc(up_pc), .upd_taken(up_t),
        .stat_lookups(lk2), .stat_mispred(mp2));
    bht_predictor #(.HIST_BITS(1), .CNT_W(CW)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_pc(lk_pc), .lk_pred(pred1),
        .upd_valid(up_v), .upd_pc(up_pc), .upd_taken(up_t),
        .stat_lookups(lk1), .stat_mispred(mp1));

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int ix(input logic [31:0] pc);
        return int'(pc[7:2]);
    endfunction

    // Driver: drive one cycle, push expected guesses, advance the model.
    task automatic step(input bit lv, input logic [31:0] lp, input bit uv,
                        input logic [31:0] upc, input bit ut, input string tag);
        item_t it;
        int u;
        @(negedge clk);
        lk_v = lv; lk_pc = lp; up_v = uv; up_pc = upc; up_t = ut;
        if (lv) begin
            it.dut = 0; it.exp = (m2[ix(lp)] >= 2); it.tag = tag; sb.push_back(it);
            it.dut = 1; it.exp = (m1[ix(lp)] == 1); sb.push_back(it);
            e_lk++;
        end
        if (uv) begin
            u = ix(upc);
            if ((m2[u] >= 2) != ut) e_mp2++;
            if ((m1[u] == 1) != ut) e_mp1++;
            if (ut && m2[u] < 3) m2[u]++;
            if (!ut && m2[u] > 0) m2[u]--;
            m1[u] = ut ? 1 : 0;
        end
    endtask

    // Let the last step land, idle the ports, compare counters.
    task automatic chk_cnt(input string tag);
        @(posedge clk); #1;
        lk_v = 0; up_v = 0;
        check(lk2 == CW'(e_lk),  {tag, " lookups 2b"}, lk2, e_lk);
        check(lk1 == CW'(e_lk),  {tag, " lookups 1b"}, lk1, e_lk);
        check(mp2 == CW'(e_mp2), {tag, " miss 2b"},    mp2, e_mp2);
        check(mp1 == CW'(e_mp1), {tag, " miss 1b"},    mp1, e_mp1);
    endtask

    // Monitor: compare guesses in the middle of the low clock phase.
    initial begin
        item_t it;
        bit got;
        forever begin
            @(negedge clk); #2;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                got = (it.dut == 0) ? pred2 : pred1;
                check(got == it.exp, $sformatf("%s dut%0d", it.tag, it.dut), got, it.exp);
            end
        end
    end

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int b2, b1;
        for (int i = 0; i < 64; i++) begin m2[i] = 1; m1[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk_cnt("R1");
        step(1, 32'h0000_0000, 0, 0, 0, "R1 entry0");
        step(1, 32'h0000_00FC, 0, 0, 0, "R1 entry63");
        step(1, 32'h0000_0040, 0, 0, 0, "R1 entry16");
        // R5/R4: one taken flips the two-bit entry from 01
        step(0, 0, 1, 32'h0000_0100, 1, "R5 upd");
        step(1, 32'h0000_0100, 0, 0, 0, "R5 one taken");
        step(0, 0, 1, 32'h0000_0100, 1, "R4 upd");
        step(0, 0, 1, 32'h0000_0100, 1, "R6 upd");
        step(0, 0, 1, 32'h0000_0100, 1, "R6 upd");
        step(0, 0, 1, 32'h0000_0100, 0, "R6 upd nt");
        // R6: saturated, one not-taken keeps taken (R3: one-bit now NT)
        step(1, 32'h0000_0100, 0, 0, 0, "R6 R3 after one nt");
        step(0, 0, 1, 32'h0000_0100, 0, "R5 upd nt");
        step(1, 32'h0000_0100, 0, 0, 0, "R5 second nt");
        chk_cnt("R9");
        // R2: alias and ignored low bits; R10: neighbour untouched
        step(0, 0, 1, 32'h0000_0204, 1, "R2 upd");
        step(0, 0, 1, 32'h0000_0204, 1, "R2 upd");
        step(1, 32'h0000_0004, 0, 0, 0, "R2 alias");
        step(1, 32'h0000_0107, 0, 0, 0, "R2 low bits");
        step(1, 32'h0000_0008, 0, 0, 0, "R10 neighbour");
        step(1, 32'h0000_0000, 0, 0, 0, "R10 entry0");
        // R7: same entry lookup and update in one cycle
        step(1, 32'h0000_0010, 1, 32'h0000_0010, 1, "R7 same cycle");
        step(1, 32'h0000_0010, 0, 0, 0, "R7 next cycle");
        step(1, 32'h0000_0310, 1, 32'h0000_0010, 0, "R7 alias same cycle");
        step(1, 32'h0000_0010, 0, 0, 0, "R7 alias next");
        chk_cnt("R8");
        // R11: loop branch, taken 9 then not taken
        b2 = 0; b1 = 0;
        for (int it = 0; it < 3; it++) begin
            if (it == 2) begin
                chk_cnt("R11 pre");
                b2 = int'(mp2); b1 = int'(mp1);
            end
            for (int k = 0; k < 10; k++)
                step(1, 32'h0000_0080, 1, 32'h0000_0080, (k < 9), "R11 loop");
        end
        chk_cnt("R11 post");
        check(int'(mp2) - b2 == 1, "R11 two-bit per loop", int'(mp2) - b2, 1);
        check(int'(mp1) - b1 == 2, "R11 one-bit per loop", int'(mp1) - b1, 2);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule